// File: doc/BRIEF.md
# Link Bring-Up Sequencer

This block steps a source-synchronous packet link through its bring-up. The link is brought up in eight phases, and an external engine carries out each one. The sequencer starts each engine with a one-cycle strobe and waits for that engine to report completion or failure. A per-phase tick budget guards every wait. The training phase is different: it completes on a count of training indications, and its budget is scaled up. Two commands start a run. A full start runs every phase. A restart is used after loss of sync and leaves out the two calendar-programming phases.

The 2-bit mode selects which directions take part. Bit 0 enables transmit and bit 1 enables receive. The phases that belong to only one direction are skipped when that direction is off. The self-test phase, clock detection, training and interface-up run in every mode, because both link clocks must be present even when only one direction is used. A failure in any phase ends the run at once and records the phase that failed. A mode of zero is refused before any phase starts.

Top module: `link_bringup_seq`

## Requirements
- R1: Phase indices, which are also the bit positions in phase_go, phase_done and phase_fail, are: 0 self-test/reset, 1 receive calendar, 2 transmit calendar, 3 clock detect, 4 training, 5 receive status sync, 6 transmit calendar lock, 7 interface up. A full start issues phase_go for the enabled phases in rising index order. phase_go is one-hot for one cycle. The strobe for phase 0 appears in the cycle after the command edge, and each later strobe appears in the cycle after the previous phase completes.
- R2: A restart issues the same order but never phases 1 and 2.
- R3: Phases 2 and 6 run only when mode bit 0 is set, and phases 1 and 5 only when mode bit 1 is set. Phases 0, 3, 4 and 7 run in every accepted mode.
- R4: phase_fail for the current phase ends the run: err=1, err_phase gives the phase index, busy falls, and no later strobe is issued. Fail takes priority over done. done and fail bits of any other phase are ignored.
- R5: The timeout counter reloads with tmo_ticks when each phase is entered. If the phase has not completed, err and err_tmo rise exactly tmo_ticks+1 cycles after that phase's strobe, with err_phase set to the phase index.
- R6: The training phase (4) completes only after TRAIN_NEED cycles with trn_ind high, counted from its strobe; phase_done[4] is ignored. The next strobe appears exactly TRAIN_NEED cycles after the training strobe when trn_ind is high every cycle. The training timeout is tmo_ticks shifted left by TRN_SHIFT.
- R7: A command with mode 0 raises err and err_mode, clears link_up, and issues no strobe and no busy.
- R8: busy is high from the cycle after an accepted command until completion or error. link_up rises when phase 7 completes and holds until the next accepted command. busy is never high together with link_up or err.
- R9: start and restart are ignored while busy: the run in progress and cal_len are unaffected.
- R10: cal_len captures ports on an accepted full start and keeps its value across restarts.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Full bring-up command pulse (wins over restart) |
| restart | input | 1 | Re-sync command pulse, skips calendar phases |
| mode | input | 2 | Bit 0 transmit, bit 1 receive, 0 invalid |
| ports | input | PW | Port count for calendar programming |
| tmo_ticks | input | TW | Per-phase timeout in cycles |
| phase_done | input | 8 | Completion from each phase engine |
| phase_fail | input | 8 | Failure from each phase engine |
| trn_ind | input | 1 | Training sequence seen indication |
| phase_go | output | 8 | One-cycle start strobe per phase |
| busy | output | 1 | Run in progress |
| link_up | output | 1 | Bring-up finished |
| err | output | 1 | Run ended in error |
| err_tmo | output | 1 | Error was a timeout |
| err_mode | output | 1 | Error was an invalid mode |
| err_phase | output | 3 | Phase index of the failure or timeout |
| cal_len | output | PW | Port count handed to the calendar engines |

## Verification
On every cycle, the checker confirms that strobes are one-hot and issued only while busy. It also confirms that restarts never strobe the calendar phases, that direction gating follows the mode latched with the command, and that busy excludes link_up and err. It further checks that an invalid mode never starts anything and that link_up rises only after interface-up completes. Some behaviours are visible only across whole scenarios: the exact phase order for each mode and command, the truncation at a failing phase, the exact cycle of a timeout, the training count, and command blocking during a run. The bench shows these by comparing the recorded strobe sequence and final flags with lists it computes itself.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam int NPH = 8;
  localparam logic [2:0] PH_RST   = 3'd0;
  localparam logic [2:0] PH_CALRX = 3'd1;
  localparam logic [2:0] PH_CALTX = 3'd2;
  localparam logic [2:0] PH_CLK   = 3'd3;
  localparam logic [2:0] PH_TRN   = 3'd4;
  localparam logic [2:0] PH_SYNRX = 3'd5;
  localparam logic [2:0] PH_SYNTX = 3'd6;
  localparam logic [2:0] PH_UP    = 3'd7;

  // mode[0] = transmit path, mode[1] = receive path
  function automatic logic ph_enabled(input logic [2:0] idx, input logic [1:0] md,
                                      input logic rerun);
    case (idx)
      PH_CALRX: ph_enabled = !rerun && md[1];
      PH_CALTX: ph_enabled = !rerun && md[0];
      PH_SYNRX: ph_enabled = md[1];
      PH_SYNTX: ph_enabled = md[0];
      default:  ph_enabled = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/lbs_next.sv
module lbs_next
  import lbs_pkg::*;
(
  input  logic [2:0] cur,
  input  logic [1:0] md,
  input  logic       rerun,
  output logic [2:0] nxt,
  output logic       last
);
  // lowest enabled index above cur; scanned downward so the lowest wins
  always_comb begin
    nxt  = cur;
    last = 1'b1;
    for (int j = NPH - 1; j >= 1; j--) begin
      if (j > int'(cur) && ph_enabled(3'(j), md, rerun)) begin
        nxt  = 3'(j);
        last = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lbs_timer.sv
module lbs_timer #(
  parameter int CW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/lbs_trn_cnt.sv
module lbs_trn_cnt #(
  parameter int NEED = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int TCW = $clog2(NEED + 1);
  logic [TCW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign hit = inc && (cnt == TCW'(NEED - 1));
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int TW         = 16,
  parameter int PW         = 6,
  parameter int TRN_SHIFT  = 3,
  parameter int TRAIN_NEED = 500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          restart,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] ports,
  input  logic [TW-1:0] tmo_ticks,
  input  logic [7:0]    phase_done,
  input  logic [7:0]    phase_fail,
  input  logic          trn_ind,
  output logic [7:0]    phase_go,
  output logic          busy,
  output logic          link_up,
  output logic          err,
  output logic          err_tmo,
  output logic          err_mode,
  output logic [2:0]    err_phase,
  output logic [PW-1:0] cal_len
);
  localparam int CW = TW + TRN_SHIFT;

  logic [2:0]    cur;
  logic [1:0]    mode_q;
  logic          rerun_q;
  logic [2:0]    nxt;
  logic          last;
  logic          cmd;
  logic          trn_hit;
  logic          done_cur, fail_cur, tmr_exp;
  logic          tmr_load;
  logic [2:0]    tgt;
  logic [CW-1:0] load_val;

  assign cmd      = (start || restart) && !busy;
  assign fail_cur = phase_fail[cur];
  assign done_cur = (cur == PH_TRN) ? trn_hit : phase_done[cur];
  assign tmr_load = cmd || (busy && !fail_cur && done_cur && !last);
  assign tgt      = cmd ? PH_RST : nxt;
  assign load_val = (tgt == PH_TRN) ? {tmo_ticks, {TRN_SHIFT{1'b0}}}
                                    : {{TRN_SHIFT{1'b0}}, tmo_ticks};

  lbs_next u_next (
    .cur(cur), .md(mode_q), .rerun(rerun_q), .nxt(nxt), .last(last)
  );

  lbs_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(load_val),
    .dec(busy), .expired(tmr_exp)
  );

  lbs_trn_cnt #(.NEED(TRAIN_NEED)) u_trn (
    .clk(clk), .rst(rst), .clr(tmr_load),
    .inc(busy && cur == PH_TRN && trn_ind), .hit(trn_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= PH_RST; mode_q <= '0; rerun_q <= 1'b0;
      phase_go <= '0; busy <= 1'b0; link_up <= 1'b0;
      err <= 1'b0; err_tmo <= 1'b0; err_mode <= 1'b0;
      err_phase <= '0; cal_len <= '0;
    end else begin
      phase_go <= '0;
      if (cmd) begin
        link_up <= 1'b0; err <= 1'b0; err_tmo <= 1'b0;
        err_mode <= 1'b0; err_phase <= '0;
        if (mode == 2'b00) begin
          err      <= 1'b1;
          err_mode <= 1'b1;
        end else begin
          busy     <= 1'b1;
          cur      <= PH_RST;
          mode_q   <= mode;
          rerun_q  <= !start;
          phase_go <= 8'(1);
          if (start) cal_len <= ports;
        end
      end else if (busy) begin
        if (fail_cur) begin
          busy <= 1'b0; err <= 1'b1; err_phase <= cur;
        end else if (done_cur) begin
          if (last) begin
            busy <= 1'b0; link_up <= 1'b1;
          end else begin
            cur      <= nxt;
            phase_go <= 8'(1) << nxt;
          end
        end else if (tmr_exp) begin
          busy <= 1'b0; err <= 1'b1; err_tmo <= 1'b1; err_phase <= cur;
        end
      end
    end
  end
endmodule

// File: rtl/lbs_chk.sv
module lbs_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       restart,
  input logic [1:0] mode,
  input logic [7:0] phase_done,
  input logic [7:0] phase_go,
  input logic       busy,
  input logic       link_up,
  input logic       err,
  input logic       err_mode
);
  logic       l_rerun;
  logic [1:0] l_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      l_rerun <= 1'b0; l_mode <= 2'b00;
    end else if ((start || restart) && !busy) begin
      l_rerun <= !start; l_mode <= mode;
    end
  end

  // R1
  go_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(phase_go));
  // R4
  go_busy_chk: assert property (@(posedge clk) disable iff (rst) (phase_go != 8'd0) |-> busy);
  // R2
  rerun_nocal_chk: assert property (@(posedge clk) disable iff (rst)
    (l_rerun && busy) |-> (!phase_go[1] && !phase_go[2]));
  // R3
  tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_go[2] || phase_go[6]) |-> l_mode[0]);
  // R3
  rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_go[1] || phase_go[5]) |-> l_mode[1]);
  // R8
  busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && (link_up || err)));
  // R8
  up_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(link_up) |-> $past(phase_done[7]));
  // R7
  mode0_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_mode) |-> (phase_go == 8'd0 && !busy));
endmodule

bind link_bringup_seq lbs_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .restart(restart), .mode(mode),
  .phase_done(phase_done), .phase_go(phase_go), .busy(busy),
  .link_up(link_up), .err(err), .err_mode(err_mode)
);

// File: tb/sim_link_bringup_seq.sv
module sim_link_bringup_seq;
  localparam int TN = 40;
  localparam int SH = 3;
  localparam int PW = 6;
  localparam int TW = 16;
  localparam int TMO = 60;

  logic clk = 0, rst = 1, start = 0, restart = 0, trn_ind = 0;
  logic [1:0] mode = 0;
  logic [PW-1:0] ports = 0;
  logic [TW-1:0] tmo_ticks = TW'(TMO);
  logic [7:0] phase_done = 0, phase_fail = 0, phase_go;
  logic busy, link_up, err, err_tmo, err_mode;
  logic [2:0] err_phase;
  logic [PW-1:0] cal_len;

  link_bringup_seq #(.TW(TW), .PW(PW), .TRN_SHIFT(SH), .TRAIN_NEED(TN)) u0 (
    .clk(clk), .rst(rst), .start(start), .restart(restart), .mode(mode),
    .ports(ports), .tmo_ticks(tmo_ticks), .phase_done(phase_done),
    .phase_fail(phase_fail), .trn_ind(trn_ind), .phase_go(phase_go),
    .busy(busy), .link_up(link_up), .err(err), .err_tmo(err_tmo),
    .err_mode(err_mode), .err_phase(err_phase), .cal_len(cal_len)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int exp_len = 0;
  int el[8];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int build(input bit rr, input bit [1:0] m);
    int n = 0;
    for (int p = 0; p < 8; p++) begin
      bit en;
      case (p)
        1: en = !rr && m[1];
        2: en = !rr && m[0];
        5: en = m[1];
        6: en = m[0];
        default: en = 1;
      endcase
      if (en) begin el[n] = p; n++; end
    end
    return n;
  endfunction

  task automatic run(input bit rr, input bit [1:0] m, input int pts,
                     input int failp, input int hangp, input bit poke);
    int seen[$];
    int gocyc[$];
    int cur = -1, cd = 0, tleft = 0, n, endcyc = 0, hang_go = -1;
    int exp_n, exp_ph = 0;
    bit done_run = 0, exp_err = 0, exp_tmo = 0;
    n = build(rr, m);
    exp_n = n;
    for (int i = 0; i < n; i++) begin
      if (el[i] == failp || el[i] == hangp) begin
        exp_n = i + 1; exp_err = 1; exp_ph = el[i]; exp_tmo = (el[i] == hangp);
        break;
      end
    end
    @(negedge clk);
    mode = m; ports = PW'(pts); start = !rr; restart = rr;
    if (!rr) exp_len = pts;
    @(negedge clk);
    start = 0; restart = 0;
    for (int i = 0; i < 3000 && !done_run; i++) begin
      phase_done = 0; phase_fail = 0; trn_ind = 0; start = 0;
      if (phase_go != 0) begin
        cur = $clog2(phase_go);
        seen.push_back(cur); gocyc.push_back(cyc);
        cd = $urandom_range(0, 3); tleft = TN;
        if (cur == hangp) hang_go = cyc;
      end
      if (!busy) begin
        done_run = 1; endcyc = cyc;
      end else begin
        if (poke && i == 5) begin start = 1; ports = PW'(pts ^ 1); end
        if (cur >= 0 && cur != hangp) begin
          if (cur == 4) begin
            if (tleft > 0) begin trn_ind = 1; tleft--; end
            phase_done[4] = 1;
          end else if (cd == 0) begin
            if (cur == failp) phase_fail[cur] = 1; else phase_done[cur] = 1;
          end else cd--;
          phase_done[(cur + 4) % 8] = 1;
          phase_fail[(cur + 3) % 8] = 1;
        end
      end
      if (!done_run) @(negedge clk);
    end
    phase_done = 0; phase_fail = 0; trn_ind = 0; start = 0;
    chk(seen.size() == exp_n, rr ? "R2" : "R1", "strobe count", seen.size(), exp_n);
    for (int i = 0; i < exp_n && i < seen.size(); i++)
      chk(seen[i] == el[i], m == 2'b11 ? "R1" : "R3", "phase order", seen[i], el[i]);
    for (int i = 0; i + 1 < seen.size(); i++)
      if (seen[i] == 4)
        chk(gocyc[i + 1] - gocyc[i] == TN, "R6", "training length",
            gocyc[i + 1] - gocyc[i], TN);
    chk(err == exp_err, "R4", "err", err, exp_err);
    chk(link_up == !exp_err, "R8", "link_up", link_up, !exp_err);
    chk(busy == 0, "R8", "busy at end", busy, 0);
    chk(err_tmo == exp_tmo, "R5", "err_tmo", err_tmo, exp_tmo);
    if (exp_err) chk(err_phase == exp_ph, "R4", "err_phase", err_phase, exp_ph);
    if (exp_tmo && hang_go >= 0) begin
      int w = (exp_ph == 4) ? (TMO << SH) + 1 : TMO + 1;
      chk(endcyc - hang_go == w, exp_ph == 4 ? "R6" : "R5", "timeout cycle",
          endcyc - hang_go, w);
    end
    chk(cal_len == PW'(exp_len), poke ? "R9" : "R10", "cal_len", cal_len, exp_len);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(phase_go == 0 && !busy && !link_up && !err && !err_tmo && !err_mode
        && err_phase == 0 && cal_len == 0, "R11", "reset outputs", phase_go, 0);
    run(0, 2'b11, 12, 8, 8, 0);  // R1 duplex full start
    run(1, 2'b11, 5, 8, 8, 0);   // R2 restart keeps cal_len R10
    run(0, 2'b01, 7, 8, 8, 0);   // R3 transmit only
    run(1, 2'b10, 9, 8, 8, 0);   // R3 receive only restart
    run(0, 2'b11, 3, 3, 8, 0);   // R4 fail at clock detect
    run(0, 2'b10, 4, 0, 8, 0);   // R4 fail at reset phase
    run(0, 2'b01, 4, 8, 6, 0);   // R5 timeout at transmit lock
    run(0, 2'b11, 4, 8, 4, 0);   // R6 timeout in training
    run(0, 2'b11, 10, 8, 8, 1);  // R9 command while busy
    // R7 invalid mode
    @(negedge clk);
    mode = 2'b00; start = 1;
    @(negedge clk);
    start = 0;
    chk(err && err_mode && !link_up && !busy && phase_go == 0, "R7", "mode zero",
        {err, err_mode, link_up, busy}, 4'b1100);
    @(negedge clk);
    chk(phase_go == 0 && !busy, "R7", "no strobe after mode zero", phase_go, 0);
    for (int k = 0; k < 24; k++) begin
      bit [1:0] m = 2'($urandom_range(1, 3));
      bit rr = $urandom_range(0, 1);
      int fp = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 7) : 8;
      int hp = (fp == 8 && $urandom_range(0, 4) == 0) ? $urandom_range(0, 7) : 8;
      run(rr, m, $urandom_range(1, 40), fp, hp, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule